// File: doc/BRIEF.md
# Flash boot-area write-protect controller

This block sits in front of an 8 Kbyte program flash (byte addresses 0x8000 to 0x9FFF, 128 pages of 64 bytes). For each write request it decides whether the write may proceed. It returns the verdict one clock after the request.

A boot-size configuration byte and its stored bitwise complement give the length of a protected run of pages that starts at page 0. If the pair is inconsistent, the block raises a configuration-fault flag and protects the whole array.

During in-application programming the array outside the boot region starts locked. It opens only after a two-byte key sequence. The boot region is never opened by those keys. During in-circuit programming every in-range write is granted, and the configuration pair is re-sampled, so the boot size can only change in that mode. A denied write sets a sticky error flag, which is cleared by a one on the clear input.

Top module: `fwp_ctrl`

## Requirements
- R1: After reset, dec_valid_o, grant_o, err_o and cfg_fault_o are 0, and the main array is locked.
- R2: The page index is (addr - 0x8000) >> 6. A boot size of 0x00 protects no page. A boot size N from 0x01 to 0x7F protects pages 0 to N-1 and no others.
- R3: A boot size above 0x7F protects all 128 pages.
- R4: If the configuration byte is not the exact bitwise inverse of its complement input, cfg_fault_o is 1 and every page is denied in application mode.
- R5: The configuration pair is captured on the first clock after reset and on every clock with icp_mode_i=1. Changes while icp_mode_i=0 have no effect.
- R6: In application mode (icp_mode_i=0) the main array is locked until key 0xA5 and then key 0x3C arrive on two consecutive key writes. Writes to unprotected pages are denied while locked and granted once unlocked.
- R7: A key write that breaks the sequence locks the main array until the next reset. Later correct keys have no effect.
- R8: Boot-region pages are denied in application mode even when the main array is unlocked.
- R9: With icp_mode_i=1, every in-range write is granted, whatever the lock state or boot size.
- R10: dec_valid_o and grant_o are registered and show the decision one clock after wr_req_i. A request outside 0x8000 to 0x9FFF gives no decision and does not touch err_o.
- R11: A denied write sets err_o, which stays set until err_clr_i=1. When a deny and a clear fall in the same cycle, the deny wins and err_o stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_byte_i | input | 8 | Boot-size configuration byte |
| cfg_inv_i | input | 8 | Stored complement of the boot-size byte |
| icp_mode_i | input | 1 | 1 = in-circuit programming, 0 = in-application programming |
| key_we_i | input | 1 | Key write strobe |
| key_i | input | 8 | Key byte |
| wr_req_i | input | 1 | Write request strobe |
| wr_addr_i | input | 16 | Byte address of the write |
| err_clr_i | input | 1 | Write-one-to-clear for err_o |
| dec_valid_o | output | 1 | A decision for an in-range request is present |
| grant_o | output | 1 | Write allowed (valid with dec_valid_o) |
| err_o | output | 1 | Sticky write-protect error |
| cfg_fault_o | output | 1 | Configuration byte and complement mismatch |

## Verification
Two functions can fall in the same cycle: setting the sticky error because a write is denied, and clearing it through err_clr_i. The bench first sets the error. It then raises err_clr_i in the same cycle as a request to a locked page, and expects err_o still to read 1 on the next cycle. A plain clear in a cycle with no deny must then bring err_o to 0.

// File: rtl/fwp_pkg.sv
package fwp_pkg;
  typedef enum logic [1:0] {
    KS_WAIT_A = 2'd0,
    KS_WAIT_B = 2'd1,
    KS_OPEN   = 2'd2,
    KS_DEAD   = 2'd3
  } key_state_e;
endpackage

// File: rtl/fwp_cfg_decode.sv
module fwp_cfg_decode #(
  parameter int CFG_W     = 8,
  parameter int NUM_PAGES = 128,
  localparam int PG_CNT_W = $clog2(NUM_PAGES) + 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [CFG_W-1:0]    cfg_byte_i,
  input  logic [CFG_W-1:0]    cfg_inv_i,
  input  logic                icp_i,
  output logic [PG_CNT_W-1:0] boot_pages_o,
  output logic                fault_o
);
  logic [CFG_W-1:0] cfg_q, inv_q;
  logic             load_q;

  // reset value: protect everything, consistent pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '1;
      inv_q  <= '0;
      load_q <= 1'b1;
    end else begin
      load_q <= 1'b0;
      if (load_q || icp_i) begin
        cfg_q <= cfg_byte_i;
        inv_q <= cfg_inv_i;
      end
    end
  end

  assign fault_o = (cfg_q != ~inv_q);

  always_comb begin
    if (fault_o || (cfg_q >= CFG_W'(NUM_PAGES)))
      boot_pages_o = PG_CNT_W'(NUM_PAGES);
    else
      boot_pages_o = PG_CNT_W'(cfg_q);
  end

  assert_cfg_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!icp_i && !load_q) |=> ($stable(cfg_q) && $stable(inv_q)));
endmodule

// File: rtl/fwp_key_lock.sv
module fwp_key_lock
  import fwp_pkg::*;
#(
  parameter int          KEY_W = 8,
  parameter logic [7:0]  KEY_A = 8'hA5,
  parameter logic [7:0]  KEY_B = 8'h3C
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             key_we_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             open_o
);
  key_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (key_we_i) begin
      unique case (st_q)
        KS_WAIT_A: st_d = (key_i == KEY_W'(KEY_A)) ? KS_WAIT_B : KS_DEAD;
        KS_WAIT_B: st_d = (key_i == KEY_W'(KEY_B)) ? KS_OPEN   : KS_DEAD;
        KS_OPEN:   st_d = KS_OPEN;
        default:   st_d = KS_DEAD;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= KS_WAIT_A;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == KS_OPEN);

  assert_dead_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == KS_DEAD) |=> (st_q == KS_DEAD));
  assert_open_needs_key_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_o && !key_we_i) |=> !open_o);
endmodule

// File: rtl/fwp_page_check.sv
module fwp_page_check #(
  parameter int ADDR_W     = 16,
  parameter int FLASH_BASE = 'h8000,
  parameter int PAGE_BYTES = 64,
  parameter int NUM_PAGES  = 128,
  localparam int PG_SHIFT  = $clog2(PAGE_BYTES),
  localparam int PG_IDX_W  = $clog2(NUM_PAGES),
  localparam int PG_CNT_W  = PG_IDX_W + 1
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [PG_CNT_W-1:0] boot_pages_i,
  output logic                in_range_o,
  output logic                boot_hit_o
);
  localparam int FLASH_BYTES = PAGE_BYTES * NUM_PAGES;
  localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(FLASH_BASE);
  localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(FLASH_BASE + FLASH_BYTES);

  logic [ADDR_W-1:0]   off;
  logic [PG_IDX_W-1:0] page;

  assign in_range_o = ({1'b0, addr_i} >= LO) && ({1'b0, addr_i} < HI);
  assign off        = addr_i - LO[ADDR_W-1:0];
  assign page       = off[PG_SHIFT +: PG_IDX_W];
  assign boot_hit_o = ({1'b0, page} < boot_pages_i);
endmodule

// File: rtl/fwp_ctrl.sv
module fwp_ctrl #(
  parameter int ADDR_W     = 16,
  parameter int CFG_W      = 8,
  parameter int FLASH_BASE = 'h8000,
  parameter int PAGE_BYTES = 64,
  parameter int NUM_PAGES  = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CFG_W-1:0]  cfg_byte_i,
  input  logic [CFG_W-1:0]  cfg_inv_i,
  input  logic              icp_mode_i,
  input  logic              key_we_i,
  input  logic [7:0]        key_i,
  input  logic              wr_req_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              err_clr_i,
  output logic              dec_valid_o,
  output logic              grant_o,
  output logic              err_o,
  output logic              cfg_fault_o
);
  localparam int PG_CNT_W = $clog2(NUM_PAGES) + 1;

  logic [PG_CNT_W-1:0] boot_pages;
  logic                unlocked, in_range, boot_hit;
  logic                decide, allow, deny;

  fwp_cfg_decode #(.CFG_W(CFG_W), .NUM_PAGES(NUM_PAGES)) u_cfg (
    .clk_i, .rst_ni,
    .cfg_byte_i, .cfg_inv_i,
    .icp_i        (icp_mode_i),
    .boot_pages_o (boot_pages),
    .fault_o      (cfg_fault_o)
  );

  fwp_key_lock #(.KEY_W(8)) u_key (
    .clk_i, .rst_ni,
    .key_we_i, .key_i,
    .open_o (unlocked)
  );

  fwp_page_check #(
    .ADDR_W(ADDR_W), .FLASH_BASE(FLASH_BASE),
    .PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)
  ) u_pg (
    .addr_i       (wr_addr_i),
    .boot_pages_i (boot_pages),
    .in_range_o   (in_range),
    .boot_hit_o   (boot_hit)
  );

  assign decide = wr_req_i && in_range;
  assign allow  = icp_mode_i || (unlocked && !boot_hit);
  assign deny   = decide && !allow;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dec_valid_o <= 1'b0;
      grant_o     <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      dec_valid_o <= decide;
      grant_o     <= decide && allow;
      // set has priority over clear
      if (deny)           err_o <= 1'b1;
      else if (err_clr_i) err_o <= 1'b0;
    end
  end

  assert_grant_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> dec_valid_o);
  assert_below_range_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_i && ({1'b0, wr_addr_i} < (ADDR_W+1)'(FLASH_BASE))) |=> !dec_valid_o);
  assert_deny_sets_err_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_o && !grant_o) |-> err_o);
  assert_fault_denies_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_fault_o && !icp_mode_i && wr_req_i) |=> !grant_o);
  assert_icp_grants_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icp_mode_i && wr_req_i) |=> (grant_o == dec_valid_o));
endmodule

// File: tb/fwp_ctrl_tb.sv
module fwp_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  cfg_byte_i = 8'h00, cfg_inv_i = 8'hFF;
  logic        icp_mode_i = 1'b0;
  logic        key_we_i = 1'b0;
  logic [7:0]  key_i = 8'h00;
  logic        wr_req_i = 1'b0;
  logic [15:0] wr_addr_i = 16'h0;
  logic        err_clr_i = 1'b0;
  logic        dec_valid_o, grant_o, err_o, cfg_fault_o;

  int total = 0;
  int bad   = 0;

  always #5 clk_i = ~clk_i;

  fwp_ctrl u_dut (.*);

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] c, input logic [7:0] ci);
    rst_ni = 1'b0; cfg_byte_i = c; cfg_inv_i = ci;
    icp_mode_i = 1'b0; key_we_i = 1'b0; wr_req_i = 1'b0; err_clr_i = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); // capture edge
  endtask

  task automatic put_key(input logic [7:0] k);
    @(negedge clk_i); key_we_i = 1'b1; key_i = k;
    @(negedge clk_i); key_we_i = 1'b0;
  endtask

  task automatic unlock();
    put_key(8'hA5); put_key(8'h3C);
  endtask

  task automatic wr(input logic [15:0] a, output logic v, output logic g);
    @(negedge clk_i); wr_req_i = 1'b1; wr_addr_i = a;
    @(negedge clk_i); v = dec_valid_o; g = grant_o; wr_req_i = 1'b0;
  endtask

  task automatic clr_err();
    @(negedge clk_i); err_clr_i = 1'b1;
    @(negedge clk_i); err_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    logic v, g;
    do_reset(8'h00, 8'hFF);
    chk("R1 valid", dec_valid_o, 1'b0);
    chk("R1 grant", grant_o, 1'b0);
    chk("R1 err", err_o, 1'b0);
    chk("R1 fault", cfg_fault_o, 1'b0);
    wr(16'h9000, v, g);
    chk("R6 locked valid", v, 1'b1);
    chk("R6 locked deny", g, 1'b0);
    chk("R11 err set", err_o, 1'b1);
    @(negedge clk_i);
    chk("R11 err sticky", err_o, 1'b1);
    clr_err();
    chk("R11 err cleared", err_o, 1'b0);
  endtask

  task automatic t_pages();
    logic v, g;
    do_reset(8'h04, 8'hFB);
    unlock();
    wr(16'h80FF, v, g); chk("R8 boot page3 deny", g, 1'b0);
    wr(16'h8100, v, g); chk("R2 page4 grant", g, 1'b1);
    wr(16'h9FFF, v, g); chk("R2 last page grant", g, 1'b1);
    wr(16'h8000, v, g); chk("R8 page0 deny", g, 1'b0);
    clr_err();
    wr(16'h7FFF, v, g); chk("R10 below range", v, 1'b0);
    wr(16'hA000, v, g); chk("R10 above range", v, 1'b0);
    chk("R10 err untouched", err_o, 1'b0);
    do_reset(8'h00, 8'hFF);
    unlock();
    wr(16'h8000, v, g); chk("R2 size0 page0 grant", g, 1'b1);
    do_reset(8'h7F, 8'h80);
    unlock();
    wr(16'h9FBF, v, g); chk("R2 page126 deny", g, 1'b0);
    wr(16'h9FC0, v, g); chk("R2 page127 grant", g, 1'b1);
    do_reset(8'h80, 8'h7F);
    unlock();
    wr(16'h9FC0, v, g); chk("R3 page127 deny", g, 1'b0);
    chk("R3 no fault", cfg_fault_o, 1'b0);
  endtask

  task automatic t_fault();
    logic v, g;
    do_reset(8'h00, 8'h00);
    chk("R4 fault flag", cfg_fault_o, 1'b1);
    unlock();
    wr(16'h9FC0, v, g); chk("R4 fault deny", g, 1'b0);
    chk("R4 fault valid", v, 1'b1);
  endtask

  task automatic t_badkey();
    logic v, g;
    do_reset(8'h00, 8'hFF);
    put_key(8'h11);
    unlock();
    wr(16'h9000, v, g); chk("R7 wrong first key", g, 1'b0);
    do_reset(8'h00, 8'hFF);
    put_key(8'hA5); put_key(8'hA5); put_key(8'h3C);
    wr(16'h9000, v, g); chk("R7 broken sequence", g, 1'b0);
    do_reset(8'h00, 8'hFF);
    unlock();
    wr(16'h9000, v, g); chk("R6 unlocked grant", g, 1'b1);
  endtask

  task automatic t_cfg_icp();
    logic v, g;
    do_reset(8'h00, 8'hFF);
    unlock();
    @(negedge clk_i); cfg_byte_i = 8'hFF; cfg_inv_i = 8'h00;
    wr(16'h8000, v, g); chk("R5 change ignored", g, 1'b1);
    @(negedge clk_i); icp_mode_i = 1'b1;
    @(negedge clk_i); icp_mode_i = 1'b0;
    wr(16'h8000, v, g); chk("R5 icp capture", g, 1'b0);
    do_reset(8'hFF, 8'h00);
    @(negedge clk_i); icp_mode_i = 1'b1;
    wr(16'h8000, v, g); chk("R9 icp boot grant", g, 1'b1);
    wr(16'h9000, v, g); chk("R9 icp locked grant", g, 1'b1);
    chk("R9 no err", err_o, 1'b0);
    @(negedge clk_i); icp_mode_i = 1'b0;
  endtask

  task automatic t_same_cycle();
    logic v, g;
    do_reset(8'h00, 8'hFF);
    wr(16'h9000, v, g);
    @(negedge clk_i); wr_req_i = 1'b1; wr_addr_i = 16'h9100; err_clr_i = 1'b1;
    @(negedge clk_i); wr_req_i = 1'b0; err_clr_i = 1'b0;
    chk("R11 set beats clear", err_o, 1'b1);
    clr_err();
    chk("R11 clear after", err_o, 1'b0);
  endtask

  initial begin
    t_reset();
    t_pages();
    t_fault();
    t_badkey();
    t_cfg_icp();
    t_same_cycle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule